// File: doc/BRIEF.md
# Adaptive-Gain All-Digital Phase-Locked Loop

This block locks a numerically controlled oscillator to a squared-up reference, such as a digitised mains or audio waveform. It produces a one-clock sync pulse that marks where a synchronous sampling frame starts. The oscillator is a phase counter that wraps at a programmable period word. A phase detector samples the counter at every reference rising edge and folds the sample into a signed phase error. A proportional-integral filter turns that error into a correction of the period word.

A supervisor moves the loop through three operating modes: fast acquisition, transition and slow tracking. It changes the loop behaviour in each mode.
- **Fast acquisition:** the centre period is preset from the measured length of the last reference cycle, and the phase is snapped straight onto the reference edge.
- **Transition and tracking:** the filter runs with gains set by right shifts. Each later mode shifts further, so the gains are smaller.
- **Lock:** the lock flag is high only while the loop is tracking.

Any large error sends the loop back to fast acquisition. With a 50 MHz clock, the 24-bit period counter covers reference frequencies from 20 Hz to 48 kHz.

Top module: `dpll_adaptive`

## Requirements
- R1: While reset is low, the phase output is 0, the sync pulse and the lock flag are low, and the mode output is 0 (fast acquisition).
- R2: The phase output steps by one per clock. On the clock where it would pass the period word minus one, it returns to 0 instead. The sync pulse is high in exactly those cycles where the phase has just returned to 0, either by wrapping or by a snap.
- R3: The reference passes through two synchronising flops. A rising reference sample taken at clock edge k is acted on at edge k+2. In fast acquisition, every acted-on edge does three things: the phase snaps to 0, the integrator clears, and the centre period and period word take the clock count between the last two edges. On the first edge after reset no measurement exists, so the centre is left unchanged.
- R4: The phase error is computed at each acted-on edge from n, the phase the counter would take next, and the period word P. The error is n if n < P/2 (integer division), and n−P otherwise. A positive error means the oscillator is early. In fast acquisition, a run of QUAL consecutive edges with |error| < COARSE moves the mode to 1 (transition).
- R5: In transition, a run of QUAL consecutive edges with |error| < FINE moves the mode to 2 (tracking). An edge with |error| ≥ COARSE returns the mode to 0. Any other edge restarts the run.
- R6: In tracking, an edge with |error| ≥ COARSE returns the mode to 0. The lock flag is high exactly while the mode is 2. The mode changes only at acted-on edges, and the value 3 never occurs.
- R7: At each acted-on edge in modes 1 and 2, the filter runs two steps. First, the integrator adds the error arithmetically shifted right by the integral shift. Second, the period word becomes centre + integrator + (error shifted right by the proportional shift), clamped to [2, 2^PER_W−1]. The shifts are KI_SH and KP_SH in mode 1, and each is larger by STEP in mode 2. The integrator changes only at acted-on edges.
- R8: The integrator saturates at ±INT_LIM. A frequency offset that would need a larger integrator drives the loop out of lock instead of winding up.
- R9: From reset, a stable reference with a period of at least 64 clocks gives lock within 8 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | 1 | Squared-up reference, asynchronous to clk |
| phase_o | output | PER_W | Oscillator phase counter |
| sync_o | output | 1 | One-clock sampling-frame pulse |
| lock_o | output | 1 | High while tracking |
| mode_o | output | 2 | Operating mode: 0 fast, 1 transition, 2 tracking |

## Verification
Several properties are checked on every clock:
- the phase steps by one or lands on zero;
- a sync pulse always coincides with a zero phase;
- fast acquisition never jumps straight to tracking, and lock only rises out of transition;
- the mode and the integrator move only on acted-on edges;
- the integrator stays within its limit.

Other behaviour needs the bench's scenarios and its cycle-accurate reference model: the exact period presets, the folded error, the qualification runs, how fast lock is reached, settling after a small frequency step, and loss of lock once the saturated integrator can no longer follow a large step.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic [1:0] {
    ST_FAST  = 2'd0,
    ST_TRAN  = 2'd1,
    ST_TRACK = 2'd2
  } mode_e;

  typedef logic signed [31:0] calc_t;

  // Fold the phase the counter will take next into a signed error.
  function automatic calc_t fold_err(calc_t nph, calc_t per);
    if (nph < (per >>> 1)) return nph;
    return nph - per;
  endfunction

  function automatic calc_t mag(calc_t v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic calc_t clip(calc_t v, calc_t lo, calc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/dpll_edge_meter.sv
module dpll_edge_meter #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  output logic             rise,
  output logic [PER_W-1:0] meas,
  output logic             meas_ok
);
  logic [1:0]       sy;
  logic             rd;
  logic [PER_W-1:0] cnt;

  assign rise = sy[1] & ~rd;
  assign meas = (cnt == '1) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy      <= '0;
      rd      <= 1'b0;
      cnt     <= '0;
      meas_ok <= 1'b0;
    end else begin
      sy <= {sy[0], ref_in};
      rd <= sy[1];
      if (rise) begin
        cnt     <= '0;
        meas_ok <= 1'b1;
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpll_supervisor.sv
module dpll_supervisor
  import dpll_pkg::*;
#(
  parameter int QUAL   = 2,
  parameter int COARSE = 64,
  parameter int FINE   = 8,
  parameter int KP_SH  = 1,
  parameter int KI_SH  = 2,
  parameter int STEP   = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise,
  input  calc_t err_mag,
  output mode_e mode,
  output logic [4:0] kp_sh,
  output logic [4:0] ki_sh
);
  localparam int QW = $clog2(QUAL + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL - 1);

  logic [QW-1:0] q;
  logic coarse_ok, fine_ok;

  assign coarse_ok = err_mag < calc_t'(COARSE);
  assign fine_ok   = err_mag < calc_t'(FINE);
  assign kp_sh = 5'(KP_SH) + ((mode == ST_TRACK) ? 5'(STEP) : 5'd0);
  assign ki_sh = 5'(KI_SH) + ((mode == ST_TRACK) ? 5'(STEP) : 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= ST_FAST;
      q    <= '0;
    end else if (rise) begin
      unique case (mode)
        ST_FAST: begin
          if (!coarse_ok)       q <= '0;
          else if (q == QLAST) begin mode <= ST_TRAN; q <= '0; end
          else                  q <= q + 1'b1;
        end
        ST_TRAN: begin
          if (!coarse_ok)       begin mode <= ST_FAST; q <= '0; end
          else if (!fine_ok)    q <= '0;
          else if (q == QLAST)  begin mode <= ST_TRACK; q <= '0; end
          else                  q <= q + 1'b1;
        end
        ST_TRACK: begin
          if (!coarse_ok)       begin mode <= ST_FAST; q <= '0; end
        end
        default: begin mode <= ST_FAST; q <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/dpll_nco_pi.sv
module dpll_nco_pi
  import dpll_pkg::*;
#(
  parameter int PER_W       = 24,
  parameter int CENTER_INIT = 400,
  parameter int INT_LIM     = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  mode_e            mode,
  input  logic [4:0]       kp_sh,
  input  logic [4:0]       ki_sh,
  input  logic [PER_W-1:0] meas,
  input  logic             meas_ok,
  output logic [PER_W-1:0] phase,
  output logic             sync,
  output calc_t            err_mag,
  output calc_t            integ,
  output logic             wrap_ev,
  output logic             snap_ev
);
  localparam calc_t MAXP = (calc_t'(1) <<< PER_W) - calc_t'(1);
  localparam int    PAD  = 32 - PER_W;

  logic [PER_W-1:0] pw, ctr, ctr_n;
  calc_t ph_c, pw_c, ctr_c, nph_c, err, integ_n, prop, pw_new;

  assign ph_c  = {{PAD{1'b0}}, phase};
  assign pw_c  = {{PAD{1'b0}}, pw};
  assign ctr_c = {{PAD{1'b0}}, ctr};
  assign ctr_n = meas_ok ? meas : ctr;

  assign wrap_ev = ph_c >= pw_c - calc_t'(1);
  assign nph_c   = wrap_ev ? calc_t'(0) : ph_c + calc_t'(1);
  assign err     = fold_err(nph_c, pw_c);
  assign err_mag = mag(err);
  assign snap_ev = rise && (mode == ST_FAST);

  assign integ_n = clip(integ + (err >>> ki_sh), calc_t'(-INT_LIM), calc_t'(INT_LIM));
  assign prop    = err >>> kp_sh;
  assign pw_new  = clip(ctr_c + integ_n + prop, calc_t'(2), MAXP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      sync  <= 1'b0;
      pw    <= PER_W'(CENTER_INIT);
      ctr   <= PER_W'(CENTER_INIT);
      integ <= '0;
    end else if (snap_ev) begin
      phase <= '0;
      sync  <= 1'b1;
      ctr   <= ctr_n;
      pw    <= ctr_n;
      integ <= '0;
    end else begin
      phase <= nph_c[PER_W-1:0];
      sync  <= wrap_ev;
      if (rise) begin
        integ <= integ_n;
        pw    <= pw_new[PER_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dpll_adaptive.sv
module dpll_adaptive
  import dpll_pkg::*;
#(
  parameter int PER_W       = 24,
  parameter int CENTER_INIT = 400,
  parameter int INT_LIM     = 1024,
  parameter int QUAL        = 2,
  parameter int COARSE      = 64,
  parameter int FINE        = 8,
  parameter int KP_SH       = 1,
  parameter int KI_SH       = 2,
  parameter int STEP        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  output logic [PER_W-1:0] phase_o,
  output logic             sync_o,
  output logic             lock_o,
  output logic [1:0]       mode_o
);
  logic             rise_ev, meas_ok, wrap_ev, snap_ev;
  logic [PER_W-1:0] meas;
  logic [4:0]       kp_sh, ki_sh;
  calc_t            err_mag, integ_mon;
  mode_e            mode;

  dpll_edge_meter #(.PER_W(PER_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .rise(rise_ev), .meas(meas), .meas_ok(meas_ok)
  );

  dpll_supervisor #(
    .QUAL(QUAL), .COARSE(COARSE), .FINE(FINE),
    .KP_SH(KP_SH), .KI_SH(KI_SH), .STEP(STEP)
  ) u_sup (
    .clk(clk), .rst_n(rst_n), .rise(rise_ev), .err_mag(err_mag),
    .mode(mode), .kp_sh(kp_sh), .ki_sh(ki_sh)
  );

  dpll_nco_pi #(
    .PER_W(PER_W), .CENTER_INIT(CENTER_INIT), .INT_LIM(INT_LIM)
  ) u_nco (
    .clk(clk), .rst_n(rst_n), .rise(rise_ev), .mode(mode),
    .kp_sh(kp_sh), .ki_sh(ki_sh), .meas(meas), .meas_ok(meas_ok),
    .phase(phase_o), .sync(sync_o), .err_mag(err_mag), .integ(integ_mon),
    .wrap_ev(wrap_ev), .snap_ev(snap_ev)
  );

  assign mode_o = mode;
  assign lock_o = (mode == ST_TRACK);
endmodule

// File: rtl/dpll_checker.sv
module dpll_checker #(
  parameter int PER_W   = 24,
  parameter int INT_LIM = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PER_W-1:0] phase_o,
  input logic             sync_o,
  input logic             lock_o,
  input logic [1:0]       mode_o,
  input logic             rise_ev,
  input logic             wrap_ev,
  input logic             snap_ev,
  input logic signed [31:0] integ_mon
);
  a_r2_sync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> phase_o == '0);

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_ev && !wrap_ev) |=> phase_o == $past(phase_o) + 1'b1);

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev || snap_ev) |=> (phase_o == '0 && sync_o));

  a_r3_snap_in_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && mode_o == 2'd0) |=> phase_o == '0);

  a_r4_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |=> mode_o != 2'd2);

  a_r5_lock_from_tran: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(mode_o) == 2'd1);

  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);

  a_r6_mode_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev |=> $stable(mode_o));

  a_r7_integ_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev |=> $stable(integ_mon));

  a_r8_integ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_mon <= INT_LIM) && (integ_mon >= -INT_LIM));
endmodule

bind dpll_adaptive dpll_checker #(.PER_W(PER_W), .INT_LIM(INT_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_o(phase_o), .sync_o(sync_o),
  .lock_o(lock_o), .mode_o(mode_o), .rise_ev(rise_ev), .wrap_ev(wrap_ev),
  .snap_ev(snap_ev), .integ_mon(integ_mon)
);

// File: tb/sim_dpll_adaptive.sv
module sim_dpll_adaptive;
  localparam int PW = 24, CI = 400, LIM = 16, QL = 2, CO = 64, FI = 8;
  localparam int KP = 1, KI = 2, ST = 1;
  localparam int MAXP = (1 << PW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0;
  logic [PW-1:0] phase_o;
  logic sync_o, lock_o;
  logic [1:0] mode_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, m_valid = 0, saw_unlock = 0;

  always #10 clk = ~clk;

  dpll_adaptive #(
    .PER_W(PW), .CENTER_INIT(CI), .INT_LIM(LIM), .QUAL(QL), .COARSE(CO),
    .FINE(FI), .KP_SH(KP), .KI_SH(KI), .STEP(ST)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .phase_o(phase_o),
    .sync_o(sync_o), .lock_o(lock_o), .mode_o(mode_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, integer arithmetic
  int m_s0, m_s1, m_rd, m_cnt, m_ok, m_ctr, m_int, m_pw, m_ph, m_sync, m_st, m_q;

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_rd = 0; m_cnt = 0; m_ok = 0;
      m_ctr = CI; m_pw = CI; m_int = 0; m_ph = 0; m_sync = 0; m_st = 0; m_q = 0;
      m_valid = 1;
    end else begin
      bit edge_seen, wrapped;
      int nxt, e, a, meas, ksh, psh, st_n, q_n;
      edge_seen = (m_s1 == 1) && (m_rd == 0);
      wrapped = m_ph >= m_pw - 1;
      nxt = wrapped ? 0 : m_ph + 1;
      e = (nxt < m_pw / 2) ? nxt : nxt - m_pw;
      a = (e < 0) ? -e : e;
      meas = (m_cnt == MAXP) ? m_cnt : m_cnt + 1;
      psh = KP + ((m_st == 2) ? ST : 0);
      ksh = KI + ((m_st == 2) ? ST : 0);
      st_n = m_st; q_n = m_q;
      if (edge_seen) begin
        if (m_st == 0) begin
          if (a >= CO) q_n = 0;
          else if (m_q == QL - 1) begin st_n = 1; q_n = 0; end
          else q_n = m_q + 1;
        end else if (m_st == 1) begin
          if (a >= CO) begin st_n = 0; q_n = 0; end
          else if (a >= FI) q_n = 0;
          else if (m_q == QL - 1) begin st_n = 2; q_n = 0; end
          else q_n = m_q + 1;
        end else if (a >= CO) begin st_n = 0; q_n = 0; end
      end
      if (edge_seen && m_st == 0) begin
        if (m_ok) m_ctr = meas;
        m_pw = m_ctr; m_ph = 0; m_int = 0; m_sync = 1;
      end else begin
        m_ph = nxt; m_sync = wrapped;
        if (edge_seen) begin
          m_int = lim(m_int + (e >>> ksh), -LIM, LIM);
          m_pw = lim(m_ctr + m_int + (e >>> psh), 2, MAXP);
        end
      end
      if (edge_seen) begin m_cnt = 0; m_ok = 1; end
      else if (m_cnt != MAXP) m_cnt = m_cnt + 1;
      m_st = st_n; m_q = q_n;
      m_rd = m_s1; m_s1 = m_s0; m_s0 = ref_in;
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      check("R2 R3 R7 R8 phase", int'(phase_o), m_ph);
      check("R2 sync", int'(sync_o), m_sync);
      check("R4 R5 R6 mode", int'(mode_o), m_st);
      check("R6 lock", int'(lock_o), (m_st == 2) ? 1 : 0);
      if (rst_n && !lock_o) saw_unlock = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R9 watchdog: actual %0d cycles expected below 190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_ref(int per, int n);
    for (int c = 0; c < n; c++)
      for (int k = 0; k < per; k++) begin
        @(negedge clk);
        ref_in = (k < per / 2);
      end
  endtask

  initial begin
    int lock_at;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 reset phase", int'(phase_o), 0);
    check("R1 reset sync", int'(sync_o), 0);
    check("R1 reset lock", int'(lock_o), 0);
    check("R1 reset mode", int'(mode_o), 0);
    rst_n = 1'b1;

    // R9: lock within 8 reference cycles
    lock_at = 0;
    for (int c = 1; c <= 8; c++) begin
      run_ref(500, 1);
      if (lock_o && lock_at == 0) lock_at = c;
    end
    check("R9 locked within 8 cycles", int'(lock_o), 1);
    run_ref(500, 4);

    // R7: small frequency step absorbed by the PI filter
    saw_unlock = 0;
    run_ref(505, 20);
    check("R7 lock kept after small step", int'(lock_o), 1);
    check("R7 no unlock during small step", int'(saw_unlock), 0);

    // R8: large offset exceeds the saturated integrator and drops lock
    saw_unlock = 0;
    run_ref(545, 16);
    check("R8 lock lost under saturated integrator", int'(saw_unlock), 1);
    // R3: reacquisition presets the centre period
    run_ref(545, 10);
    check("R3 relock at new period", int'(lock_o), 1);

    // R6: abrupt jump to a short period forces reacquisition
    saw_unlock = 0;
    run_ref(200, 12);
    check("R6 unlock seen after jump", int'(saw_unlock), 1);
    check("R6 relock after jump", int'(lock_o), 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule